// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked design read and write an external asynchronous static RAM of 32K bytes that has one shared bidirectional data bus. A user presents a request with a strobe, a read/write flag, a 15-bit address and, for writes, a data byte. The controller then runs the memory strobes (active-low chip enable, output enable and write enable) through timed phases. When the access is complete it raises a one-cycle completion pulse and, for a read, shows the byte it captured.

Each phase length comes from nanosecond timing parameters and the clock period. The parameter is divided by the period and rounded up to whole cycles. The longest rule that applies to a phase sets its length. After every read the controller adds a turnaround gap with every strobe deasserted. This gives the memory time to release the bus before the controller can drive it. The controller drives the bus only while write enable is low.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_ce_n, mem_oe_n and mem_we_n are 1, req_ready is 1 and done is 0.
- R2: The controller accepts a request (req_valid high at a clock edge) only while req_ready is 1. While req_ready is 0, req_valid has no effect: it causes no memory access, no write and no extra done pulse.
- R3: A read holds mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for exactly RD_CYC consecutive cycles. This is 10 with the defaults. mem_addr stays constant for as long as mem_ce_n is 0.
- R4: The byte on the bus is captured at the end of the last read cycle. It appears on rdata in the same cycle as the done pulse, and it equals the last byte written to that address.
- R5: A write holds mem_ce_n=0 and mem_we_n=0 with mem_oe_n=1 for exactly WR_CYC cycles (10 with the defaults). The write byte is driven onto mem_dq only while mem_we_n is 0. The pulse covers at least 70 ns of write-enable width, 80 ns from chip enable and 40 ns of data setup. The memory stores the byte that was driven.
- R6: Each phase count is the ceiling of its nanosecond value divided by CLK_PERIOD_NS, with a minimum of 1. The defaults are a 10 ns period, 100 ns read and write cycles and a 30 ns release time, giving 10, 10 and 3 cycles.
- R7: After a read, req_ready stays 0 for exactly TURN_CYC cycles (3 with the defaults) with all strobes at 1. Write enable falls no sooner than 30 ns after output enable rises.
- R8: done is high for a single cycle, exactly once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Controller idle, a request may be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq | inout | 8 | Shared memory data bus |

## Verification
The bench writes the lowest, highest and alternating-bit addresses with the bytes 00, FF, A5 and 5A. It then reads them back, along with one address that was never written. Together these reads separate address decoding faults from data path faults. Pairs such as write-then-read on one address and read-then-write on one address expose missing turnaround and stale capture. A memory model that presents a poison byte until 99 ns after the last address or strobe change tells a shortened access phase apart from a correct one. Requests raised while the controller is busy show whether the idle-only acceptance holds.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

    parameter int unsigned ADDR_BITS = 15;
    parameter int unsigned DATA_BITS = 8;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_TURN  = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    typedef struct packed {
        logic                 wr;
        logic [ADDR_BITS-1:0] addr;
        logic [DATA_BITS-1:0] data;
    } req_t;

    // ceiling of ns / period, never below one cycle
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          last
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
    import asram_pkg::*;
#(
    parameter int unsigned RD_CYC   = 10,
    parameter int unsigned WR_CYC   = 10,
    parameter int unsigned TURN_CYC = 3,
    parameter int unsigned CW       = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  req_t                 req,
    input  logic                 phase_last,
    output logic                 load,
    output logic [CW-1:0]        load_val,
    output logic                 capture,
    output logic                 ready,
    output logic                 done,
    output logic                 ce_n,
    output logic                 oe_n,
    output logic                 we_n,
    output logic                 drive,
    output logic [ADDR_BITS-1:0] addr,
    output logic [DATA_BITS-1:0] wdata
);
    localparam logic [CW-1:0] RD_LOAD   = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LOAD   = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] TURN_LOAD = CW'(TURN_CYC - 1);

    phase_e st, nxt;
    logic   accept;
    logic   finish;

    assign accept = (st == PH_IDLE) && req_valid;
    assign finish = phase_last && ((st == PH_READ) || (st == PH_WRITE));
    assign ready  = (st == PH_IDLE);

    always_comb begin
        nxt      = st;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        unique case (st)
            PH_IDLE: begin
                if (req_valid) begin
                    nxt      = req.wr ? PH_WRITE : PH_READ;
                    load     = 1'b1;
                    load_val = req.wr ? WR_LOAD : RD_LOAD;
                end
            end
            PH_READ: begin
                if (phase_last) begin
                    capture  = 1'b1;
                    nxt      = PH_TURN;
                    load     = 1'b1;
                    load_val = TURN_LOAD;
                end
            end
            PH_TURN: begin
                if (phase_last) nxt = PH_IDLE;
            end
            PH_WRITE: begin
                if (phase_last) nxt = PH_IDLE;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    // strobes are registered from the next phase so the pins never glitch
    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= PH_IDLE;
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            drive <= 1'b0;
            done  <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else begin
            st    <= nxt;
            ce_n  <= !((nxt == PH_READ) || (nxt == PH_WRITE));
            oe_n  <= (nxt != PH_READ);
            we_n  <= (nxt != PH_WRITE);
            drive <= (nxt == PH_WRITE);
            done  <= finish;
            if (accept) begin
                addr  <= req.addr;
                wdata <= req.data;
            end
        end
    end

    assert_idle_deselected_R1: assert property (@(posedge clk) disable iff (rst)
        ready |-> (ce_n && oe_n && we_n && !drive));

    assert_busy_holds_addr_R2: assert property (@(posedge clk) disable iff (rst)
        !ready |=> $stable(addr));

    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));

    assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(!oe_n && !we_n));

    assert_drive_only_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        drive |-> (!we_n && !ce_n && oe_n));

    assert_turn_after_read_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_n) |-> (!ready && ce_n));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/asram_dq_port.sv
`timescale 1ns/1ps
module asram_dq_port
    import asram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 drive,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 capture,
    inout  wire  [DATA_BITS-1:0] dq,
    output logic [DATA_BITS-1:0] rdata
);
    assign dq = drive ? wdata : {DATA_BITS{1'bz}};

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= dq;
        end
    end

    assert_no_capture_while_driving_R4: assert property (@(posedge clk) disable iff (rst)
        capture |-> !drive);

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_RC_NS       = 100,
    parameter int unsigned T_AA_NS       = 100,
    parameter int unsigned T_AOE_NS      = 50,
    parameter int unsigned T_WC_NS       = 100,
    parameter int unsigned T_WP_NS       = 70,
    parameter int unsigned T_AW_NS       = 80,
    parameter int unsigned T_DW_NS       = 40,
    parameter int unsigned T_OHZ_NS      = 30
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_BITS-1:0] req_addr,
    input  logic [DATA_BITS-1:0] req_wdata,
    output logic                 req_ready,
    output logic                 done,
    output logic [DATA_BITS-1:0] rdata,
    output logic                 mem_ce_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [ADDR_BITS-1:0] mem_addr,
    inout  wire  [DATA_BITS-1:0] mem_dq
);
    localparam int unsigned RD_CYC = umax(umax(ns2cyc(T_RC_NS, CLK_PERIOD_NS),
                                               ns2cyc(T_AA_NS, CLK_PERIOD_NS)),
                                          ns2cyc(T_AOE_NS, CLK_PERIOD_NS));
    localparam int unsigned WR_CYC = umax(umax(ns2cyc(T_WC_NS, CLK_PERIOD_NS),
                                               ns2cyc(T_WP_NS, CLK_PERIOD_NS)),
                                          umax(ns2cyc(T_AW_NS, CLK_PERIOD_NS),
                                               ns2cyc(T_DW_NS, CLK_PERIOD_NS)));
    localparam int unsigned TURN_CYC = ns2cyc(T_OHZ_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC  = umax(umax(RD_CYC, WR_CYC), TURN_CYC);
    localparam int unsigned CW       = $clog2(MAX_CYC + 1);

    req_t                 req;
    logic                 load;
    logic [CW-1:0]        load_val;
    logic                 phase_last;
    logic                 capture;
    logic                 drive;
    logic [DATA_BITS-1:0] wdata;

    assign req = '{wr: req_write, addr: req_addr, data: req_wdata};

    asram_phase_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .last     (phase_last)
    );

    asram_seq #(
        .RD_CYC   (RD_CYC),
        .WR_CYC   (WR_CYC),
        .TURN_CYC (TURN_CYC),
        .CW       (CW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req        (req),
        .phase_last (phase_last),
        .load       (load),
        .load_val   (load_val),
        .capture    (capture),
        .ready      (req_ready),
        .done       (done),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .drive      (drive),
        .addr       (mem_addr),
        .wdata      (wdata)
    );

    asram_dq_port u_dq (
        .clk     (clk),
        .rst     (rst),
        .drive   (drive),
        .wdata   (wdata),
        .capture (capture),
        .dq      (mem_dq),
        .rdata   (rdata)
    );

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
    localparam int CLK_NS = 10;
    localparam int RD_EXP = 10;
    localparam int WR_EXP = 10;
    localparam int TURN_EXP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rdata;
    logic        ce_n, oe_n, we_n;
    logic [14:0] mem_addr;
    wire  [7:0]  dq;

    int checks = 0;
    int errors = 0;
    int ops_issued = 0;
    int dones_seen = 0;

    always #(CLK_NS/2) clk = ~clk;

    asram_ctrl u_asram_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .mem_ce_n(ce_n), .mem_oe_n(oe_n),
        .mem_we_n(we_n), .mem_addr(mem_addr), .mem_dq(dq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_ge(input string tag, input realtime act, input realtime lim);
        checks++;
        if (act < lim) begin
            errors++;
            $display("FAIL %s actual=%0.1f ns expected>=%0.1f ns", tag, act, lim);
        end
    endtask

    // ---------------- behavioural memory ----------------
    logic [7:0] mcell [int];
    logic       mdrv = 1'b0;
    logic [7:0] mval = '0;
    assign dq = mdrv ? mval : 8'bz;

    function automatic logic [7:0] dflt(input int a);
        return a[7:0] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] cell_rd(input int a);
        return mcell.exists(a) ? mcell[a] : dflt(a);
    endfunction

    realtime t_oe_f = 0, t_ce_f = 0, t_addr = 0, t_we_f = 0, t_wd = 0, t_rel = -1000;
    logic       wfirst = 1'b0;
    logic [7:0] wlast = '0;
    logic [14:0] waddr = '0;

    always @(negedge oe_n) t_oe_f = $realtime;
    always @(negedge ce_n) t_ce_f = $realtime;
    always @(mem_addr) t_addr = $realtime;
    always @(posedge oe_n) begin
        if (!rst) check_ge("R3 read strobe width", $realtime - t_oe_f, 100.0);
        t_rel = $realtime;
    end
    always @(negedge we_n) begin
        if (!rst) check_ge("R7 bus release before write", $realtime - t_rel, 30.0);
        t_we_f = $realtime;
        wfirst = 1'b1;
    end
    always @(posedge we_n) begin
        if (!rst) begin
            check_ge("R5 write pulse width", $realtime - t_we_f, 70.0);
            check_ge("R5 chip enable to write end", $realtime - t_ce_f, 80.0);
            check_ge("R5 data setup", $realtime - t_wd, 39.0);
            mcell[int'(waddr)] = wlast;
        end
    end

    initial begin
        realtime now, last_chg;
        #0.5;
        forever begin
            now = $realtime;
            if (!ce_n && !oe_n && we_n) begin
                last_chg = (t_oe_f > t_ce_f) ? t_oe_f : t_ce_f;
                if (t_addr > last_chg) last_chg = t_addr;
                mdrv = 1'b1;
                mval = (now - last_chg >= 99.0) ? cell_rd(int'(mem_addr)) : 8'hEE;
            end else if (we_n && (now - t_rel < 29.0)) begin
                mdrv = mdrv;
            end else begin
                mdrv = 1'b0;
            end
            if (!we_n && !ce_n) begin
                if (wfirst) begin
                    wlast = dq; waddr = mem_addr; t_wd = now; wfirst = 1'b0;
                end else if (dq !== wlast) begin
                    wlast = dq; t_wd = now;
                end
            end
            #1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { bit rd; logic [7:0] d; logic [14:0] a; } item_t;
    item_t sbq[$];
    logic [7:0] ref_mem [int];

    task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        it.rd = !wr; it.a = a;
        if (wr) begin
            ref_mem[int'(a)] = d; it.d = d;
        end else begin
            it.d = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : dflt(int'(a));
        end
        sbq.push_back(it);
        ops_issued++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    logic        done_prev = 1'b0;
    logic        ce_prev = 1'b1;
    logic [14:0] addr_prev = '0;
    int oe_cnt = 0, we_cnt = 0, turn_cnt = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                dones_seen++;
                check("R8 done width", {31'd0, done_prev}, 32'd0);
                if (sbq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R8 done without request actual=1 expected=0");
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    if (it.rd) check($sformatf("R4 read data @%0h", it.a), {24'd0, rdata}, {24'd0, it.d});
                end
            end
            done_prev = done;
            if (!ce_n && !ce_prev) check("R3 address stable", {17'd0, mem_addr}, {17'd0, addr_prev});
            ce_prev = ce_n; addr_prev = mem_addr;
            if (!oe_n) oe_cnt++;
            else if (oe_cnt != 0) begin
                check("R3,R6 read cycles", oe_cnt, RD_EXP); oe_cnt = 0;
            end
            if (!we_n) we_cnt++;
            else if (we_cnt != 0) begin
                check("R5,R6 write cycles", we_cnt, WR_EXP); we_cnt = 0;
            end
            if (!req_ready && ce_n && oe_n && we_n) turn_cnt++;
            else if (req_ready && turn_cnt != 0) begin
                check("R7,R6 turnaround cycles", turn_cnt, TURN_EXP); turn_cnt = 0;
            end
        end else begin
            done_prev = 1'b0;
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 50000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 ce_n in reset", {31'd0, ce_n}, 32'd1);
        check("R1 we_n in reset", {31'd0, we_n}, 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ce_n", {31'd0, ce_n}, 32'd1);
        check("R1 oe_n", {31'd0, oe_n}, 32'd1);
        check("R1 we_n", {31'd0, we_n}, 32'd1);
        check("R1 ready", {31'd0, req_ready}, 32'd1);
        check("R1 done", {31'd0, done}, 32'd0);

        // corner addresses and data patterns
        do_op(1'b1, 15'h0000, 8'hA5);
        do_op(1'b1, 15'h7FFF, 8'h5A);
        do_op(1'b1, 15'h5555, 8'hFF);
        do_op(1'b1, 15'h2AAA, 8'h00);
        do_op(1'b0, 15'h0000, 8'h00);
        do_op(1'b0, 15'h7FFF, 8'h00);
        do_op(1'b0, 15'h5555, 8'h00);
        do_op(1'b0, 15'h2AAA, 8'h00);
        do_op(1'b0, 15'h1234, 8'h00);
        // write then read, read then write on one address
        do_op(1'b1, 15'h0100, 8'hC3);
        do_op(1'b0, 15'h0100, 8'h00);
        do_op(1'b0, 15'h0000, 8'h00);
        do_op(1'b1, 15'h0000, 8'h77);
        do_op(1'b0, 15'h0000, 8'h00);

        // R2: request raised while busy must be ignored
        do_op(1'b0, 15'h4444, 8'h00);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0100; req_wdata = 8'h55;
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        do_op(1'b0, 15'h0100, 8'h00);

        while (sbq.size() != 0 || !req_ready) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R2 done count equals accepted requests", dones_seen, ops_issued);
        check("R1 idle strobes at end", {29'd0, ce_n, oe_n, we_n}, 32'd7);
        summary();
    end

endmodule